// File: doc/BRIEF.md
# Dual-CPU Mailbox Doorbell Controller

This block sits between a host processor and an embedded coprocessor. It gives both of them a word-addressed register window. Through that window they pass commands and replies in a bank of 64 shared scratch words, and they signal each other with doorbell bits.

Two doorbell groups run in opposite directions. Each group has five registers: a set (generate) register, a clear register, a mask, the raw pending status and the masked status. The host-to-coprocessor group splits its bits into a data field at bits 0..5 and a control field at bits 16..25. The coprocessor-to-host group uses bits 0..9. A third group gathers 26 level lines from peripheral blocks and reports them to the host. The block also provides:
- a software-reset bit that holds the coprocessor in reset,
- a boot base register,
- general-purpose output and output-enable registers,
- a general-purpose input register read through a two-flop synchronizer.

The host normally writes a command code into scratch word 0, the sensor ID into word 1 and parameters into words 2..5. It then sets a doorbell and polls masked-status bit 0 until the coprocessor clears it. The coprocessor answers in words 10..15 and rings the opposite group.

Top module: `mbx_doorbell_ctrl`

## Requirements
- R1: After reset every register reads 0, and `cop_reset`, `cop_irq`, `host_irq`, `gpio_out` and `gpio_oe` are all low.
- R2: Word offsets are as follows. Control is at 0x00, boot base at 0x04, general-purpose output at 0x40, output enable at 0x44 and general-purpose input at 0x48. Control, boot base, the masks, output and output enable are read/write, and bits beyond each field read 0. Control bit 0 drives `cop_reset`, which stays high for as long as the bit is set.
- R3: Writing 1 to a bit of a generate register (host-to-coprocessor at 0x08, coprocessor-to-host at 0x1C) sets that status bit. Writing 0 has no effect. A set bit holds until it is cleared. Only bits 0..5 and 16..25 exist in host-to-coprocessor status (0x14), and only bits 0..9 exist in coprocessor-to-host status (0x28).
- R4: Writing 1 to a bit of a clear register (0x0C, 0x20) drops that status bit, and 0 bits have no effect. Writing back a status value that was read clears exactly those bits.
- R5: If a set and a clear reach the same status bit in one cycle, the bit ends up set.
- R6: Masked status (0x18, 0x2C, 0x3C) equals status AND NOT mask (0x10, 0x24, 0x34), where a mask bit of 1 blocks the source. `cop_irq` is the OR of host-to-coprocessor masked status. `host_irq` is the OR of coprocessor-to-host and peripheral masked status.
- R7: Peripheral sources 0..5 latch into status (0x38) on a rising edge of `peri_in`. They are cleared only by writing 1 to bit 16+n of 0x30; bit n of 0x30 does nothing. Status bits of sources 6..25 follow their input level one cycle later. The peripheral mask has 26 bits.
- R8: The 64 scratch words sit at 0x80 + 4·n. Either port can read and write them, and each port sees what the other wrote.
- R9: When both ports write the same register or scratch word in the same cycle, the host's value is kept.
- R10: Read data appears on the port's `rdata` one cycle after the read request. Generate and clear registers and unmapped words read 0.
- R11: The general-purpose input register returns `gpio_in` through two flops. A read issued in the first cycle the pins change returns the old value, and a read issued two cycles later returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_en | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 9 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one cycle after request |
| c_en | input | 1 | Coprocessor access request |
| c_we | input | 1 | Coprocessor write (1) or read (0) |
| c_addr | input | 9 | Coprocessor byte address |
| c_wdata | input | 32 | Coprocessor write data |
| c_rdata | output | 32 | Coprocessor read data, one cycle after request |
| peri_in | input | 26 | Peripheral interrupt lines |
| gpio_in | input | 18 | General-purpose input pins |
| gpio_out | output | 18 | General-purpose output value |
| gpio_oe | output | 18 | General-purpose output enable |
| cop_reset | output | 1 | Coprocessor software reset |
| cop_irq | output | 1 | Doorbell interrupt to coprocessor |
| host_irq | output | 1 | Doorbell and peripheral interrupt to host |

## Verification
The sensitive overlap is a doorbell set and a clear of the same status bit landing in one cycle, typically the host ringing again while the coprocessor acknowledges the previous ring. The bench provokes this directly, with a host generate and a coprocessor clear on the same bit next to a clear of another pending bit. It also provokes it at random, by driving both ports with independent random operations over a narrow address set so that generate, clear and same-word scratch writes often coincide. A reference model applies clear-then-set with host-wins priority, and every read and both interrupt lines are compared against it.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the mailbox doorbell controller.
// Assumes a 9-bit byte address; the word index is address[8:2].
package mbx_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 9;
    localparam int WIDX_W = ADDR_W - 2;

    typedef logic [WIDX_W-1:0] widx_t;
    typedef logic [DATA_W-1:0] word_t;

    // Word indices of the register window (byte offset = index * 4)
    localparam widx_t W_CTRL     = widx_t'(0);
    localparam widx_t W_BOOT     = widx_t'(1);
    localparam widx_t W_H2C_GEN  = widx_t'(2);
    localparam widx_t W_H2C_CLR  = widx_t'(3);
    localparam widx_t W_H2C_MSK  = widx_t'(4);
    localparam widx_t W_H2C_ST   = widx_t'(5);
    localparam widx_t W_H2C_MST  = widx_t'(6);
    localparam widx_t W_C2H_GEN  = widx_t'(7);
    localparam widx_t W_C2H_CLR  = widx_t'(8);
    localparam widx_t W_C2H_MSK  = widx_t'(9);
    localparam widx_t W_C2H_ST   = widx_t'(10);
    localparam widx_t W_C2H_MST  = widx_t'(11);
    localparam widx_t W_PERI_CLR = widx_t'(12);
    localparam widx_t W_PERI_MSK = widx_t'(13);
    localparam widx_t W_PERI_ST  = widx_t'(14);
    localparam widx_t W_PERI_MST = widx_t'(15);
    localparam widx_t W_GPO      = widx_t'(16);
    localparam widx_t W_GPOE     = widx_t'(17);
    localparam widx_t W_GPI      = widx_t'(18);
    localparam int    SCR_BASE   = 32;

    // Implemented doorbell bits per direction
    localparam word_t H2C_VALID = 32'h03FF_003F;
    localparam word_t C2H_VALID = 32'h0000_03FF;

    // Peripheral clear field position
    localparam int PERI_CLR_LSB = 16;
endpackage

// File: rtl/mbx_irq_group.sv
`timescale 1ns/1ps
// One interrupt group: pending status with set/clear, mask, masked status, OR line.
// Assumes set and clear vectors are already aligned to status bit positions.
// Bits in LEVEL follow lvl_vec instead of latching; bits outside VALID stay 0.
module mbx_irq_group #(
    parameter int          W     = 32,
    parameter logic [W-1:0] VALID = '1,
    parameter logic [W-1:0] LEVEL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    input  logic [W-1:0] lvl_vec,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic [W-1:0] masked,
    output logic         irq
);
    localparam logic [W-1:0] STICKY = VALID & ~LEVEL;

    // Pending status: clear first, then set, so a set in the same cycle wins
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= ((LEVEL & lvl_vec) | (~LEVEL & ((status & ~clr_vec) | set_vec))) & VALID;
    end

    // Mask register, 1 blocks the source
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata & VALID;
    end

    // Masked view and the combined interrupt line
    always_comb begin
        masked = status & ~mask;
        irq    = |masked;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) // R5
        ((set_vec & STICKY) != '0) |=> ((status & $past(set_vec & STICKY)) == $past(set_vec & STICKY)));

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n) // R4
        ((clr_vec & ~set_vec & STICKY) != '0) |=> ((status & $past(clr_vec & ~set_vec & STICKY)) == '0));

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R3
        1'b1 |=> ((($past(status) & ~$past(clr_vec) & STICKY) & ~status) == '0));
endmodule

// File: rtl/mbx_scratch.sv
`timescale 1ns/1ps
// Shared scratch bank with one write/read port per side.
// Assumes both sides share the clock; same-word writes in one cycle keep the host's data.
module mbx_scratch #(
    parameter int WORDS = 64,
    parameter int DW    = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_we,
    input  logic [IW-1:0] h_idx,
    input  logic [DW-1:0] h_wd,
    input  logic          c_we,
    input  logic [IW-1:0] c_idx,
    input  logic [DW-1:0] c_wd,
    output logic [DW-1:0] h_rd,
    output logic [DW-1:0] c_rd
);
    logic [DW-1:0] mem [WORDS];

    // Word storage, host write has priority over the coprocessor's
    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n)                           mem[i] <= '0;
            else if (h_we && h_idx == IW'(i))     mem[i] <= h_wd;
            else if (c_we && c_idx == IW'(i))     mem[i] <= c_wd;
        end
    end

    // Asynchronous read per side; the top registers the result
    always_comb begin
        h_rd = mem[h_idx];
        c_rd = mem[c_idx];
    end

    AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n) // R9
        (h_we && c_we && h_idx == c_idx) |=> (mem[$past(h_idx)] == $past(h_wd)));

    AST_COP_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) // R8
        (c_we && !(h_we && h_idx == c_idx)) |=> (mem[$past(c_idx)] == $past(c_wd)));
endmodule

// File: rtl/mbx_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a bus of independent static input pins.
// Assumes each pin is sampled on its own; no cross-bit coherence is promised.
module mbx_sync2 #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // First and second capture flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/mbx_doorbell_ctrl.sv
`timescale 1ns/1ps
// Mailbox doorbell controller between a host and a coprocessor.
// Each side has a word-addressed read/write port into the whole map; reads return
// one cycle after the request. Writes from both sides in one cycle: the host's
// data wins for plain registers and scratch words; generate and clear bits from
// both sides are merged, and a set beats a clear.
module mbx_doorbell_ctrl #(
    parameter int SCR_WORDS = 64,
    parameter int GPIO_W    = 18,
    parameter int PERI_W    = 26,
    parameter int PERI_EDGE = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      h_en,
    input  logic                      h_we,
    input  logic [mbx_pkg::ADDR_W-1:0] h_addr,
    input  logic [31:0]               h_wdata,
    output logic [31:0]               h_rdata,
    input  logic                      c_en,
    input  logic                      c_we,
    input  logic [mbx_pkg::ADDR_W-1:0] c_addr,
    input  logic [31:0]               c_wdata,
    output logic [31:0]               c_rdata,
    input  logic [PERI_W-1:0]         peri_in,
    input  logic [GPIO_W-1:0]         gpio_in,
    output logic [GPIO_W-1:0]         gpio_out,
    output logic [GPIO_W-1:0]         gpio_oe,
    output logic                      cop_reset,
    output logic                      cop_irq,
    output logic                      host_irq
);
    import mbx_pkg::*;

    localparam int    SCR_IW     = $clog2(SCR_WORDS);
    localparam int    NPORT      = 2;
    localparam widx_t SCR_LO     = widx_t'(SCR_BASE);
    localparam widx_t SCR_HI     = widx_t'(SCR_BASE + SCR_WORDS - 1);
    localparam word_t PERI_VALID = word_t'((64'd1 << PERI_W) - 1);
    localparam word_t EDGE_BITS  = word_t'((64'd1 << PERI_EDGE) - 1);
    localparam word_t PERI_LEVEL = PERI_VALID & ~EDGE_BITS;

    // Per-port request view; index 0 is the host, 1 the coprocessor
    logic  [NPORT-1:0] p_wr, p_rd, p_scr;
    widx_t             p_idx   [NPORT];
    word_t             p_wd    [NPORT];
    word_t             p_rnow  [NPORT];
    word_t             p_rq    [NPORT];
    word_t             scr_rd  [NPORT];
    logic [SCR_IW-1:0] scr_idx [NPORT];

    // Register state
    logic              ctrl_q;
    word_t             boot_q;
    logic [GPIO_W-1:0] gpo_q, gpoe_q, gpi_s;
    logic [PERI_EDGE-1:0] peri_prev;

    word_t h2c_set, h2c_clr, h2c_st, h2c_msk, h2c_mst;
    word_t c2h_set, c2h_clr, c2h_st, c2h_msk, c2h_mst;
    word_t peri_set, peri_clr, peri_st, peri_msk, peri_mst;
    logic  h2c_irq, c2h_irq, peri_irq;

    logic  h2c_msk_we, c2h_msk_we, peri_msk_we;
    word_t h2c_msk_wd, c2h_msk_wd, peri_msk_wd;
    logic  ctrl_we;

    // Address bits below word granularity are not decoded
    logic  unused_ok;
    assign unused_ok = &{1'b0, h_addr[1:0], c_addr[1:0]};

    // Gather both ports into arrays so the decode is written once
    always_comb begin
        p_wr[0] = h_en && h_we;   p_rd[0] = h_en && !h_we;
        p_wr[1] = c_en && c_we;   p_rd[1] = c_en && !c_we;
        p_idx[0] = h_addr[ADDR_W-1:2];
        p_idx[1] = c_addr[ADDR_W-1:2];
        p_wd[0]  = h_wdata;
        p_wd[1]  = c_wdata;
    end

    // Write decode: a write hit on word w from port p
    function automatic logic hit(input logic wr, input widx_t idx, input widx_t w);
        return wr && (idx == w);
    endfunction

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            // Scratch window membership and local index
            always_comb begin
                p_scr[p]   = (p_idx[p] >= SCR_LO) && (p_idx[p] <= SCR_HI);
                scr_idx[p] = SCR_IW'(p_idx[p] - SCR_LO);
            end

            // Read multiplexer for this port
            always_comb begin
                if (p_scr[p]) begin
                    p_rnow[p] = scr_rd[p];
                end else begin
                    case (p_idx[p])
                        W_CTRL:     p_rnow[p] = {31'b0, ctrl_q};
                        W_BOOT:     p_rnow[p] = boot_q;
                        W_H2C_MSK:  p_rnow[p] = h2c_msk;
                        W_H2C_ST:   p_rnow[p] = h2c_st;
                        W_H2C_MST:  p_rnow[p] = h2c_mst;
                        W_C2H_MSK:  p_rnow[p] = c2h_msk;
                        W_C2H_ST:   p_rnow[p] = c2h_st;
                        W_C2H_MST:  p_rnow[p] = c2h_mst;
                        W_PERI_MSK: p_rnow[p] = peri_msk;
                        W_PERI_ST:  p_rnow[p] = peri_st;
                        W_PERI_MST: p_rnow[p] = peri_mst;
                        W_GPO:      p_rnow[p] = word_t'(gpo_q);
                        W_GPOE:     p_rnow[p] = word_t'(gpoe_q);
                        W_GPI:      p_rnow[p] = word_t'(gpi_s);
                        default:    p_rnow[p] = '0;
                    endcase
                end
            end

            // Read data register, loaded on a read request
            always_ff @(posedge clk) begin
                if (!rst_n)       p_rq[p] <= '0;
                else if (p_rd[p]) p_rq[p] <= p_rnow[p];
            end
        end
    endgenerate

    assign h_rdata = p_rq[0];
    assign c_rdata = p_rq[1];

    // Doorbell set/clear vectors merged from both ports
    always_comb begin
        h2c_set = (hit(p_wr[0], p_idx[0], W_H2C_GEN) ? p_wd[0] : '0) |
                  (hit(p_wr[1], p_idx[1], W_H2C_GEN) ? p_wd[1] : '0);
        h2c_clr = (hit(p_wr[0], p_idx[0], W_H2C_CLR) ? p_wd[0] : '0) |
                  (hit(p_wr[1], p_idx[1], W_H2C_CLR) ? p_wd[1] : '0);
        c2h_set = (hit(p_wr[0], p_idx[0], W_C2H_GEN) ? p_wd[0] : '0) |
                  (hit(p_wr[1], p_idx[1], W_C2H_GEN) ? p_wd[1] : '0);
        c2h_clr = (hit(p_wr[0], p_idx[0], W_C2H_CLR) ? p_wd[0] : '0) |
                  (hit(p_wr[1], p_idx[1], W_C2H_CLR) ? p_wd[1] : '0);
    end

    // Peripheral edge detect and clear-field realignment
    always_comb begin
        peri_set = '0;
        peri_clr = '0;
        for (int n = 0; n < PERI_EDGE; n++) begin
            peri_set[n] = peri_in[n] && !peri_prev[n];
            peri_clr[n] = (hit(p_wr[0], p_idx[0], W_PERI_CLR) && p_wd[0][PERI_CLR_LSB+n]) ||
                          (hit(p_wr[1], p_idx[1], W_PERI_CLR) && p_wd[1][PERI_CLR_LSB+n]);
        end
    end

    // Previous level of the edge-latched peripheral lines
    always_ff @(posedge clk) begin
        if (!rst_n) peri_prev <= '0;
        else        peri_prev <= peri_in[PERI_EDGE-1:0];
    end

    // Mask writes, host data first
    always_comb begin
        h2c_msk_we  = hit(p_wr[0], p_idx[0], W_H2C_MSK)  || hit(p_wr[1], p_idx[1], W_H2C_MSK);
        c2h_msk_we  = hit(p_wr[0], p_idx[0], W_C2H_MSK)  || hit(p_wr[1], p_idx[1], W_C2H_MSK);
        peri_msk_we = hit(p_wr[0], p_idx[0], W_PERI_MSK) || hit(p_wr[1], p_idx[1], W_PERI_MSK);
        h2c_msk_wd  = hit(p_wr[0], p_idx[0], W_H2C_MSK)  ? p_wd[0] : p_wd[1];
        c2h_msk_wd  = hit(p_wr[0], p_idx[0], W_C2H_MSK)  ? p_wd[0] : p_wd[1];
        peri_msk_wd = hit(p_wr[0], p_idx[0], W_PERI_MSK) ? p_wd[0] : p_wd[1];
        ctrl_we     = hit(p_wr[0], p_idx[0], W_CTRL)     || hit(p_wr[1], p_idx[1], W_CTRL);
    end

    // Plain read/write registers, host data wins on a same-cycle collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 1'b0;
            boot_q <= '0;
            gpo_q  <= '0;
            gpoe_q <= '0;
        end else begin
            if      (hit(p_wr[0], p_idx[0], W_CTRL)) ctrl_q <= p_wd[0][0];
            else if (hit(p_wr[1], p_idx[1], W_CTRL)) ctrl_q <= p_wd[1][0];
            if      (hit(p_wr[0], p_idx[0], W_BOOT)) boot_q <= p_wd[0];
            else if (hit(p_wr[1], p_idx[1], W_BOOT)) boot_q <= p_wd[1];
            if      (hit(p_wr[0], p_idx[0], W_GPO))  gpo_q  <= p_wd[0][GPIO_W-1:0];
            else if (hit(p_wr[1], p_idx[1], W_GPO))  gpo_q  <= p_wd[1][GPIO_W-1:0];
            if      (hit(p_wr[0], p_idx[0], W_GPOE)) gpoe_q <= p_wd[0][GPIO_W-1:0];
            else if (hit(p_wr[1], p_idx[1], W_GPOE)) gpoe_q <= p_wd[1][GPIO_W-1:0];
        end
    end

    mbx_irq_group #(.W(DATA_W), .VALID(H2C_VALID), .LEVEL('0)) u_h2c (
        .clk(clk), .rst_n(rst_n), .set_vec(h2c_set), .clr_vec(h2c_clr), .lvl_vec('0),
        .mask_we(h2c_msk_we), .mask_wdata(h2c_msk_wd),
        .status(h2c_st), .mask(h2c_msk), .masked(h2c_mst), .irq(h2c_irq));

    mbx_irq_group #(.W(DATA_W), .VALID(C2H_VALID), .LEVEL('0)) u_c2h (
        .clk(clk), .rst_n(rst_n), .set_vec(c2h_set), .clr_vec(c2h_clr), .lvl_vec('0),
        .mask_we(c2h_msk_we), .mask_wdata(c2h_msk_wd),
        .status(c2h_st), .mask(c2h_msk), .masked(c2h_mst), .irq(c2h_irq));

    mbx_irq_group #(.W(DATA_W), .VALID(PERI_VALID), .LEVEL(PERI_LEVEL)) u_peri (
        .clk(clk), .rst_n(rst_n), .set_vec(peri_set), .clr_vec(peri_clr), .lvl_vec(word_t'(peri_in)),
        .mask_we(peri_msk_we), .mask_wdata(peri_msk_wd),
        .status(peri_st), .mask(peri_msk), .masked(peri_mst), .irq(peri_irq));

    mbx_scratch #(.WORDS(SCR_WORDS), .DW(DATA_W)) u_scr (
        .clk(clk), .rst_n(rst_n),
        .h_we(p_wr[0] && p_scr[0]), .h_idx(scr_idx[0]), .h_wd(p_wd[0]),
        .c_we(p_wr[1] && p_scr[1]), .c_idx(scr_idx[1]), .c_wd(p_wd[1]),
        .h_rd(scr_rd[0]), .c_rd(scr_rd[1]));

    mbx_sync2 #(.W(GPIO_W)) u_gpi (
        .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(gpi_s));

    // Output drive
    always_comb begin
        cop_reset = ctrl_q;
        gpio_out  = gpo_q;
        gpio_oe   = gpoe_q;
        cop_irq   = h2c_irq;
        host_irq  = c2h_irq | peri_irq;
    end

    AST_COP_RESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R2
        !ctrl_we |=> $stable(cop_reset));

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R10
        !h_en |=> $stable(h_rdata));
endmodule

// File: tb/tb_mbx_doorbell_ctrl.sv
`timescale 1ns/1ps
module tb_mbx_doorbell_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_en = 0, h_we = 0, c_en = 0, c_we = 0;
    logic [8:0]  h_addr = '0, c_addr = '0;
    logic [31:0] h_wdata = '0, c_wdata = '0;
    logic [31:0] h_rdata, c_rdata;
    logic [25:0] peri_in = '0;
    logic [17:0] gpio_in = '0;
    logic [17:0] gpio_out, gpio_oe;
    logic        cop_reset, cop_irq, host_irq;

    int n_chk = 0, n_fail = 0;
    logic [31:0] h_rs, c_rs, tmp;
    logic [31:0] m_scr [64];
    logic [31:0] m_h2c, m_c2h;

    localparam logic [31:0] H2C_OK = 32'h03FF_003F;
    localparam logic [31:0] C2H_OK = 32'h0000_03FF;

    always #5 clk = ~clk;

    mbx_doorbell_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .h_en(h_en), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .c_en(c_en), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .peri_in(peri_in), .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .cop_reset(cop_reset), .cop_irq(cop_irq), .host_irq(host_irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic he, hw, input logic [8:0] ha, input logic [31:0] hd,
                       input logic ce, cw, input logic [8:0] ca, input logic [31:0] cd);
        @(negedge clk);
        h_en = he; h_we = hw; h_addr = ha; h_wdata = hd;
        c_en = ce; c_we = cw; c_addr = ca; c_wdata = cd;
        @(posedge clk); #1;
        h_rs = h_rdata; c_rs = c_rdata;
    endtask

    task automatic idle();        cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic hwr(input logic [8:0] a, input logic [31:0] d); cyc(1, 1, a, d, 0, 0, 0, 0); endtask
    task automatic cwr(input logic [8:0] a, input logic [31:0] d); cyc(0, 0, 0, 0, 1, 1, a, d); endtask
    task automatic hrd(input logic [8:0] a, output logic [31:0] v); cyc(1, 0, a, 0, 0, 0, 0, 0); v = h_rs; endtask
    task automatic crd(input logic [8:0] a, output logic [31:0] v); cyc(0, 0, 0, 0, 1, 0, a, 0); v = c_rs; endtask

    // Model read value for the random phase
    function automatic logic [31:0] m_read(input logic [8:0] a);
        if (a >= 9'h080 && a < 9'h180) return m_scr[(a - 9'h080) >> 2];
        case (a)
            9'h014, 9'h018: return m_h2c;
            9'h028, 9'h02C: return m_c2h;
            default:        return 32'h0;
        endcase
    endfunction

    // Random operation for one port: returns enable, write, address, data
    task automatic pick(output logic en, we, output logic [8:0] a, output logic [31:0] d);
        int op = $urandom_range(0, 6);
        logic hi = $urandom_range(0, 1) == 1;
        en = 1; we = 0; d = $urandom; a = 0;
        case (op)
            0: begin we = 1; a = 9'(9'h080 + 4 * $urandom_range(0, 7)); end
            1: a = 9'(9'h080 + 4 * $urandom_range(0, 7));
            2: begin we = 1; a = hi ? 9'h01C : 9'h008; end
            3: begin we = 1; a = hi ? 9'h020 : 9'h00C; end
            4: a = hi ? 9'h028 : 9'h014;
            5: a = hi ? 9'h02C : 9'h018;
            default: en = 0;
        endcase
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset state
        chk("R1 cop_reset", {31'b0, cop_reset}, 0);
        chk("R1 cop_irq",   {31'b0, cop_irq}, 0);
        chk("R1 host_irq",  {31'b0, host_irq}, 0);
        chk("R1 gpio_out",  {14'b0, gpio_out}, 0);
        for (int a = 0; a <= 'h48; a += 4) begin
            hrd(9'(a), tmp); chk($sformatf("R1 reg %h", a), tmp, 0);
        end
        crd(9'h17C, tmp); chk("R1 scratch", tmp, 0);

        // R2: plain registers and the reset hold
        hwr(9'h000, 32'hFFFF_FFFF);
        chk("R2 cop_reset set", {31'b0, cop_reset}, 1);
        idle(); idle();
        chk("R2 cop_reset held", {31'b0, cop_reset}, 1);
        crd(9'h000, tmp); chk("R2 ctrl readback", tmp, 1);
        hwr(9'h000, 0);
        chk("R2 cop_reset released", {31'b0, cop_reset}, 0);
        hwr(9'h004, 32'hA5A5_1234); crd(9'h004, tmp); chk("R2 boot", tmp, 32'hA5A5_1234);
        hwr(9'h040, 32'hFFFF_FFFF); hrd(9'h040, tmp); chk("R2 gpo read", tmp, 32'h3FFFF);
        chk("R2 gpio_out", {14'b0, gpio_out}, 32'h3FFFF);
        cwr(9'h044, 32'h0001_2345); chk("R2 gpio_oe", {14'b0, gpio_oe}, 32'h12345);

        // R3: generate sets only implemented bits, zeros have no effect
        hwr(9'h008, 32'hFFFF_FFFF); crd(9'h014, tmp); chk("R3 h2c status", tmp, H2C_OK);
        chk("R6 cop_irq on", {31'b0, cop_irq}, 1);
        hwr(9'h008, 0); crd(9'h014, tmp); chk("R3 zero write no effect", tmp, H2C_OK);
        hrd(9'h008, tmp); chk("R10 generate reads 0", tmp, 0);

        // R4: clear and write-back clear
        cwr(9'h00C, 32'h0000_0005); crd(9'h014, tmp); chk("R4 partial clear", tmp, H2C_OK & ~32'h5);
        crd(9'h014, tmp); cwr(9'h00C, tmp); hrd(9'h014, tmp); chk("R4 write-back clear", tmp, 0);
        chk("R6 cop_irq off", {31'b0, cop_irq}, 0);

        // R6: masking
        hwr(9'h010, 32'h1); hwr(9'h008, 32'h1);
        hrd(9'h018, tmp); chk("R6 masked hidden", tmp, 0);
        hrd(9'h014, tmp); chk("R6 raw visible", tmp, 1);
        chk("R6 cop_irq masked", {31'b0, cop_irq}, 0);
        hwr(9'h010, 0); chk("R6 cop_irq unmasked", {31'b0, cop_irq}, 1);
        hrd(9'h018, tmp); chk("R6 masked shown", tmp, 1);

        // R5: same-cycle set and clear
        hwr(9'h008, 32'h2);
        cyc(1, 1, 9'h008, 32'h1, 1, 1, 9'h00C, 32'h3);
        hrd(9'h014, tmp); chk("R5 set beats clear", tmp, 32'h1);
        cwr(9'h00C, 32'hFFFF_FFFF);
        cwr(9'h01C, 32'hFFFF_FFFF); hrd(9'h028, tmp); chk("R3 c2h status", tmp, C2H_OK);
        chk("R6 host_irq c2h", {31'b0, host_irq}, 1);
        cyc(1, 1, 9'h020, 32'hFFFF_FFFF, 1, 1, 9'h01C, 32'h200);
        hrd(9'h028, tmp); chk("R5 c2h set beats clear", tmp, 32'h200);
        hwr(9'h020, 32'hFFFF_FFFF); chk("R6 host_irq off", {31'b0, host_irq}, 0);

        // R7: peripheral group
        peri_in[2] = 1'b1; idle();
        chk("R7 host_irq peri", {31'b0, host_irq}, 1);
        peri_in[2] = 1'b0; idle();
        hrd(9'h038, tmp); chk("R7 edge latched", tmp, 32'h4);
        hwr(9'h030, 32'h4); hrd(9'h038, tmp); chk("R7 low clear bit ignored", tmp, 32'h4);
        hwr(9'h030, 32'h1 << 18); hrd(9'h038, tmp); chk("R7 clear at 16+n", tmp, 0);
        peri_in[10] = 1'b1; idle(); hrd(9'h038, tmp); chk("R7 level source high", tmp, 32'h400);
        peri_in[10] = 1'b0; idle(); hrd(9'h038, tmp); chk("R7 level source low", tmp, 0);
        hwr(9'h034, 32'hFFFF_FFFF); hrd(9'h034, tmp); chk("R7 26-bit mask", tmp, 32'h03FF_FFFF);
        peri_in[3] = 1'b1; idle();
        hrd(9'h03C, tmp); chk("R6 peri masked", tmp, 0);
        hrd(9'h038, tmp); chk("R7 peri raw", tmp, 32'h8);
        chk("R6 host_irq peri masked", {31'b0, host_irq}, 0);
        peri_in = '0; hwr(9'h030, 32'h1 << 19); hwr(9'h034, 0);

        // R8: scratch crossing between ports
        hwr(9'h080, 32'hC0DE_0001); hwr(9'h17C, 32'h7777_0063);
        crd(9'h080, tmp); chk("R8 word0 host->cop", tmp, 32'hC0DE_0001);
        crd(9'h17C, tmp); chk("R8 word63 host->cop", tmp, 32'h7777_0063);
        cwr(9'h0A8, 32'h2000_0000); hrd(9'h0A8, tmp); chk("R8 word10 cop->host", tmp, 32'h2000_0000);

        // R9: same-cycle writes to the same word
        cyc(1, 1, 9'h084, 32'h1111, 1, 1, 9'h084, 32'h2222);
        crd(9'h084, tmp); chk("R9 scratch host wins", tmp, 32'h1111);
        cyc(1, 1, 9'h004, 32'hAAAA, 1, 1, 9'h004, 32'hBBBB);
        crd(9'h004, tmp); chk("R9 boot host wins", tmp, 32'hAAAA);

        // R10: unmapped words
        hrd(9'h04C, tmp); chk("R10 unmapped 0x4C", tmp, 0);
        hrd(9'h07C, tmp); chk("R10 unmapped 0x7C", tmp, 0);
        crd(9'h180, tmp); chk("R10 beyond scratch", tmp, 0);

        // R11: synchronizer latency
        gpio_in = 18'h2AAAA;
        hrd(9'h048, tmp); chk("R11 first cycle old value", tmp, 0);
        hrd(9'h048, tmp);
        hrd(9'h048, tmp); chk("R11 synced value", tmp, 32'h2AAAA);

        // Random phase: both ports at once, against the model
        hwr(9'h00C, 32'hFFFF_FFFF); hwr(9'h020, 32'hFFFF_FFFF);
        m_h2c = 0; m_c2h = 0;
        for (int k = 0; k < 64; k++) begin
            m_scr[k] = 32'h0101_0101 * k;
            hwr(9'(9'h080 + 4 * k), m_scr[k]);
        end
        for (int it = 0; it < 600; it++) begin
            logic he, hw, ce, cw;
            logic [8:0] ha, ca;
            logic [31:0] hd, cd, eh, ec, set_h, clr_h, set_c, clr_c;
            pick(he, hw, ha, hd);
            pick(ce, cw, ca, cd);
            eh = m_read(ha); ec = m_read(ca);
            cyc(he, hw, ha, hd, ce, cw, ca, cd);
            set_h = ((he && hw && ha == 9'h008) ? hd : 0) | ((ce && cw && ca == 9'h008) ? cd : 0);
            clr_h = ((he && hw && ha == 9'h00C) ? hd : 0) | ((ce && cw && ca == 9'h00C) ? cd : 0);
            set_c = ((he && hw && ha == 9'h01C) ? hd : 0) | ((ce && cw && ca == 9'h01C) ? cd : 0);
            clr_c = ((he && hw && ha == 9'h020) ? hd : 0) | ((ce && cw && ca == 9'h020) ? cd : 0);
            m_h2c = ((m_h2c & ~clr_h) | set_h) & H2C_OK;
            m_c2h = ((m_c2h & ~clr_c) | set_c) & C2H_OK;
            if (ce && cw && ca >= 9'h080) m_scr[(ca - 9'h080) >> 2] = cd;
            if (he && hw && ha >= 9'h080) m_scr[(ha - 9'h080) >> 2] = hd;
            if (he && !hw) chk("R5 R8 R9 random host read", h_rs, eh);
            if (ce && !cw) chk("R5 R8 R9 random cop read", c_rs, ec);
            chk("R6 random cop_irq", {31'b0, cop_irq}, {31'b0, |m_h2c});
            chk("R6 random host_irq", {31'b0, host_irq}, {31'b0, |m_c2h});
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule